// File: doc/BRIEF.md
# Pointer-Register Data Address Generator

This block forms the data-space address for every load and store of a small 8-bit processor core. It holds three 16-bit general pointers (X, Y, Z) and a 16-bit stack pointer. For each accepted request it presents one memory access: a registered address, a read or write strobe, and the store byte. In the final cycle of the operation it raises a one-cycle `done` pulse, and it reports any pointer it changed on a write-back channel.

The addressing modes are plain indirect, post-increment, pre-decrement, pointer-plus-displacement, direct, stack push and stack pop. A set-pointer mode loads a pointer from the request's address field. Plain, post-increment, push and set-pointer finish one cycle after acceptance. Pre-decrement, displacement, direct and pop spend one extra preparation cycle first, and `req_ready` is low during that cycle. No mode touches any processor status flag. All pointer arithmetic wraps modulo 2^16.

Top module: `ptr_agu`

## Requirements
- R1: After reset X, Y and Z are 0x0000 and the stack pointer is 0xFFFF. `req_ready` is 1, and `done`, `mem_rd`, `mem_wr` and `wb_valid` are 0.
- R2: Mode 7 (set pointer) loads `req_addr` into the pointer chosen by `req_sel` (0=X, 1=Y, 2=Z, 3=stack pointer). It completes in one cycle with no memory strobe, and `wb_valid` reports the new value.
- R3: Mode 0 (plain) accesses the selected pointer's value in one cycle and leaves the pointer unchanged, with no write-back. `req_write`=1 selects a store and 0 a load.
- R4: Mode 1 (post-increment) accesses the current pointer value in one cycle. The pointer then becomes value+1, wrapping 0xFFFF to 0x0000, and the new value is written back.
- R5: Mode 2 (pre-decrement) takes two cycles. It accesses pointer-1, wrapping 0x0000 to 0xFFFF, and that value is written back as the new pointer.
- R6: Mode 3 (displacement) takes two cycles. It accesses Y or Z plus the zero-extended 6-bit `req_disp`, wrapping modulo 2^16, and leaves the pointer unchanged.
- R7: Mode 4 (direct) takes two cycles and accesses `req_addr`. It reads or writes according to `req_write`, and no pointer changes.
- R8: Mode 5 (push) writes `req_wdata` at the stack pointer in one cycle, ignoring `req_write` and `req_sel`. The stack pointer is then decremented and written back.
- R9: Mode 6 (pop) takes two cycles, ignoring `req_write` and `req_sel`. The stack pointer is first incremented, the read uses the incremented value, and that value is written back.
- R10: `ld_data` equals `mem_rdata` while `mem_rd` is high.
- R11: `req_ready` is low exactly during the first cycle of a two-cycle mode, and a request presented then is ignored. `done` is high in the final cycle of every operation. Each strobe lasts one cycle, and a strobe is never raised without `done`.
- R12: An illegal request is refused: no strobe, no `done`, and no pointer change. Illegal means `req_sel`=3 with modes 0 to 2, or displacement with `req_sel` other than Y or Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_mode | input | 3 | Addressing mode code (0..7) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_sel | input | 2 | Pointer select: 0=X, 1=Y, 2=Z, 3=stack pointer |
| req_disp | input | 6 | Unsigned displacement |
| req_addr | input | 16 | Direct address or value for set-pointer |
| req_wdata | input | 8 | Store byte |
| mem_rdata | input | 8 | Read byte from data memory |
| req_ready | output | 1 | Block can accept a request this cycle |
| mem_addr | output | 16 | Data-space address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write |
| done | output | 1 | Final cycle of an operation |
| ld_data | output | 8 | Loaded byte |
| wb_valid | output | 1 | A pointer was updated |
| wb_sel | output | 2 | Which pointer was updated |
| wb_value | output | 16 | Updated pointer value |

## Verification
Every mode is run on X, Y and Z for pointer values 0x0000, 0x0001, 0x1234 and 0xFFFF, in both directions. This separates the modes by address, latency and write-back, and exposes wrap errors at both ends of the range. All 64 displacements are swept from a base of 0xFFF0, which distinguishes zero-extension from sign-extension and shows the carry wrapping. Push and pop sequences cross address zero, which tells post-decrement from pre-increment ordering. Refused requests and a request presented during a preparation cycle are each followed by a plain access, so the bench can see whether any pointer was disturbed.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

    typedef enum logic [2:0] {
        MODE_PLAIN   = 3'd0,
        MODE_POSTINC = 3'd1,
        MODE_PREDEC  = 3'd2,
        MODE_DISP    = 3'd3,
        MODE_DIRECT  = 3'd4,
        MODE_PUSH    = 3'd5,
        MODE_POP     = 3'd6,
        MODE_SETPTR  = 3'd7
    } agu_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_PREP = 2'd2
    } agu_state_e;

    localparam logic [1:0] SEL_X  = 2'd0;
    localparam logic [1:0] SEL_Y  = 2'd1;
    localparam logic [1:0] SEL_Z  = 2'd2;
    localparam logic [1:0] SEL_SP = 2'd3;

endpackage

// File: rtl/ptr_agu_decode.sv
module ptr_agu_decode
    import ptr_agu_pkg::*;
(
    input  agu_mode_e  mode,
    input  logic [1:0] sel,
    output logic       legal,
    output logic       two_cycle,
    output logic       on_stack
);
    always_comb begin
        legal     = 1'b1;
        two_cycle = 1'b0;
        on_stack  = 1'b0;
        unique case (mode)
            MODE_PLAIN, MODE_POSTINC: legal = (sel != SEL_SP);
            MODE_PREDEC: begin
                legal     = (sel != SEL_SP);
                two_cycle = 1'b1;
            end
            MODE_DISP: begin
                legal     = (sel == SEL_Y) || (sel == SEL_Z);
                two_cycle = 1'b1;
            end
            MODE_DIRECT: two_cycle = 1'b1;
            MODE_PUSH:   on_stack  = 1'b1;
            MODE_POP: begin
                on_stack  = 1'b1;
                two_cycle = 1'b1;
            end
            MODE_SETPTR: legal = 1'b1;
            default:     legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptr_agu_arith.sv
module ptr_agu_arith #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] plus_one,
    output logic [AW-1:0] minus_one,
    output logic [AW-1:0] plus_off
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        plus_one  = base + ONE;
        minus_one = base - ONE;
        plus_off  = base + offset;
    end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import ptr_agu_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 8,
    parameter int            DISPW    = 6,
    parameter logic [AW-1:0] SP_RESET = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_mode,
    input  logic          req_write,
    input  logic [1:0]    req_sel,
    input  logic [DISPW-1:0] req_disp,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          req_ready,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          done,
    output logic [DW-1:0] ld_data,
    output logic          wb_valid,
    output logic [1:0]    wb_sel,
    output logic [AW-1:0] wb_value
);
    localparam int NPTR = 4;
    localparam int PADW = AW - DISPW;

    typedef struct packed {
        agu_state_e                st;
        logic [NPTR-1:0][AW-1:0]   ptr;
        logic [AW-1:0]             addr;
        logic                      rd;
        logic                      wr;
        logic [DW-1:0]             wdata;
        logic                      done;
        logic                      wbv;
        logic [1:0]                wbsel;
        logic [AW-1:0]             wbval;
        agu_mode_e                 pmode;
        logic                      pwrite;
        logic [1:0]                psel;
        logic [AW-1:0]             poff;
    } agu_regs_t;

    agu_regs_t r_d, r_q;

    agu_mode_e     mode_in;
    logic          legal, two_cycle, on_stack;
    logic [1:0]    eff_sel;
    logic          accept;
    logic [AW-1:0] base, offset, disp_ext;
    logic [AW-1:0] plus_one, minus_one, plus_off;

    assign mode_in  = agu_mode_e'(req_mode);
    assign disp_ext = {{PADW{1'b0}}, req_disp};

    ptr_agu_decode u_dec (
        .mode      (mode_in),
        .sel       (req_sel),
        .legal     (legal),
        .two_cycle (two_cycle),
        .on_stack  (on_stack)
    );

    assign eff_sel = on_stack ? SEL_SP : req_sel;
    assign accept  = req_valid && legal && (r_q.st != ST_PREP);

    // Base and offset come from the pending operation while preparing.
    always_comb begin
        if (r_q.st == ST_PREP) begin
            base   = r_q.ptr[r_q.psel];
            offset = r_q.poff;
        end else begin
            base   = r_q.ptr[eff_sel];
            offset = disp_ext;
        end
    end

    ptr_agu_arith #(.AW(AW)) u_arith (
        .base      (base),
        .offset    (offset),
        .plus_one  (plus_one),
        .minus_one (minus_one),
        .plus_off  (plus_off)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rd    = 1'b0;
        r_d.wr    = 1'b0;
        r_d.done  = 1'b0;
        r_d.wbv   = 1'b0;
        r_d.st    = ST_IDLE;

        if (r_q.st == ST_PREP) begin
            // Second cycle: issue the access prepared in the first.
            r_d.st   = ST_ACC;
            r_d.done = 1'b1;
            r_d.rd   = !r_q.pwrite;
            r_d.wr   = r_q.pwrite;
            unique case (r_q.pmode)
                MODE_DISP:   r_d.addr = plus_off;
                MODE_DIRECT: r_d.addr = r_q.poff;
                default: begin
                    r_d.addr  = base;
                    r_d.wbv   = 1'b1;
                    r_d.wbsel = r_q.psel;
                    r_d.wbval = base;
                end
            endcase
        end else if (accept) begin
            r_d.wdata  = req_wdata;
            r_d.pmode  = mode_in;
            r_d.psel   = eff_sel;
            r_d.pwrite = req_write;
            if (two_cycle) begin
                r_d.st = ST_PREP;
            end else begin
                r_d.st   = ST_ACC;
                r_d.done = 1'b1;
            end
            unique case (mode_in)
                MODE_SETPTR: begin
                    r_d.ptr[eff_sel] = req_addr;
                    r_d.wbv          = 1'b1;
                    r_d.wbsel        = eff_sel;
                    r_d.wbval        = req_addr;
                end
                MODE_PLAIN: begin
                    r_d.addr = base;
                    r_d.rd   = !req_write;
                    r_d.wr   = req_write;
                end
                MODE_POSTINC: begin
                    r_d.addr         = base;
                    r_d.rd           = !req_write;
                    r_d.wr           = req_write;
                    r_d.ptr[eff_sel] = plus_one;
                    r_d.wbv          = 1'b1;
                    r_d.wbsel        = eff_sel;
                    r_d.wbval        = plus_one;
                end
                MODE_PUSH: begin
                    r_d.addr         = base;
                    r_d.wr           = 1'b1;
                    r_d.ptr[eff_sel] = minus_one;
                    r_d.wbv          = 1'b1;
                    r_d.wbsel        = eff_sel;
                    r_d.wbval        = minus_one;
                end
                MODE_PREDEC: r_d.ptr[eff_sel] = minus_one;
                MODE_POP: begin
                    r_d.ptr[eff_sel] = plus_one;
                    r_d.pwrite       = 1'b0;
                end
                MODE_DISP:   r_d.poff = disp_ext;
                MODE_DIRECT: r_d.poff = req_addr;
                default:     r_d.poff = r_q.poff;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q            <= '0;
            r_q.ptr[SEL_SP] <= SP_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st != ST_PREP);
    assign mem_addr  = r_q.addr;
    assign mem_rd    = r_q.rd;
    assign mem_wr    = r_q.wr;
    assign mem_wdata = r_q.wdata;
    assign done      = r_q.done;
    assign ld_data   = r_q.rd ? mem_rdata : '0;
    assign wb_valid  = r_q.wbv;
    assign wb_sel    = r_q.wbsel;
    assign wb_value  = r_q.wbval;

endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic mem_rd,
    input logic mem_wr,
    input logic done,
    input logic wb_valid
);
    // R11: one access direction at a time
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11: a strobe only appears in the final cycle
    assert_strobe_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> done);

    // R11: preparation lasts a single cycle and ends in completion
    assert_prep_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (req_ready && done));

    // R5: nothing is issued in the preparation cycle
    assert_prep_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (!done && !mem_rd && !mem_wr));

    // R2: a pointer write-back always coincides with completion
    assert_wb_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);
endmodule

bind ptr_agu ptr_agu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .done      (done),
    .wb_valid  (wb_valid)
);

// File: tb/tb_ptr_agu.sv
`timescale 1ns/1ps
module tb_ptr_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_sel = '0;
    logic [5:0]  req_disp = '0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  mem_rdata;
    logic        req_ready, mem_rd, mem_wr, done, wb_valid;
    logic [15:0] mem_addr, wb_value;
    logic [7:0]  mem_wdata, ld_data;
    logic [1:0]  wb_sel;

    int checks = 0;
    int failures = 0;
    logic [15:0] mp [4];

    always #10 clk = ~clk;

    assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'hA5;

    ptr_agu dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_write(req_write), .req_sel(req_sel), .req_disp(req_disp),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
        .req_ready(req_ready), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .done(done), .ld_data(ld_data),
        .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_value(wb_value)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(int m);
        case (m)
            0: return "R3";  1: return "R4";  2: return "R5";  3: return "R6";
            4: return "R7";  5: return "R8";  6: return "R9";  default: return "R2";
        endcase
    endfunction

    // Drive one request at a negedge and check its outcome against the model.
    task automatic run_op(int m, bit w, int s, int d, logic [15:0] a, logic [7:0] wd);
        int  es = (m == 5 || m == 6) ? 3 : s;
        bit  legal = 1'b1;
        bit  two = (m == 2 || m == 3 || m == 4 || m == 6);
        bit  erd = 1'b0, ewr = 1'b0, ewb = 1'b0;
        logic [15:0] p, np, ea;
        string t = mode_tag(m);
        if (m <= 2 && s == 3) legal = 1'b0;
        if (m == 3 && !(s == 1 || s == 2)) legal = 1'b0;
        p = mp[es]; np = p; ea = p;
        case (m)
            0: ea = p;
            1: begin ea = p; np = p + 16'd1; end
            2: begin np = p - 16'd1; ea = np; end
            3: ea = p + {10'd0, d[5:0]};
            4: ea = a;
            5: begin ea = p; np = p - 16'd1; end
            6: begin np = p + 16'd1; ea = np; end
            default: np = a;
        endcase
        if (m <= 4) begin erd = !w; ewr = w; end
        if (m == 5) ewr = 1'b1;
        if (m == 6) erd = 1'b1;
        ewb = (m == 1 || m == 2 || m == 5 || m == 6 || m == 7);
        req_valid = 1'b1; req_mode = 3'(m); req_write = w; req_sel = 2'(s);
        req_disp = 6'(d); req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (!legal) begin
            chk("R12", "done", {31'd0, done}, 0);
            chk("R12", "strobes", {30'd0, mem_rd, mem_wr}, 0);
            chk("R12", "ready", {31'd0, req_ready}, 1);
            return;
        end
        if (two) begin
            chk("R11", "prep ready", {31'd0, req_ready}, 0);
            chk("R11", "prep done", {31'd0, done}, 0);
            @(negedge clk);
        end
        chk(t, "done", {31'd0, done}, 1);
        chk(t, "ready", {31'd0, req_ready}, 1);
        chk(t, "rd", {31'd0, mem_rd}, {31'd0, erd});
        chk(t, "wr", {31'd0, mem_wr}, {31'd0, ewr});
        if (erd || ewr) chk(t, "addr", {16'd0, mem_addr}, {16'd0, ea});
        if (ewr) chk(t, "wdata", {24'd0, mem_wdata}, {24'd0, wd});
        if (erd) chk("R10", "ld_data", {24'd0, ld_data},
                     {24'd0, ea[7:0] ^ ea[15:8] ^ 8'hA5});
        chk(t, "wb_valid", {31'd0, wb_valid}, {31'd0, ewb});
        if (ewb) begin
            chk(t, "wb_sel", {30'd0, wb_sel}, es);
            chk(t, "wb_value", {16'd0, wb_value}, {16'd0, np});
        end
        mp[es] = np;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] vals [4] = '{16'h0000, 16'h0001, 16'h1234, 16'hFFFF};
        mp[0] = 16'h0; mp[1] = 16'h0; mp[2] = 16'h0; mp[3] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "ready", {31'd0, req_ready}, 1);
        chk("R1", "done", {31'd0, done}, 0);
        chk("R1", "strobes", {30'd0, mem_rd, mem_wr}, 0);
        chk("R1", "wb_valid", {31'd0, wb_valid}, 0);
        for (int s = 0; s < 3; s++) run_op(0, 1'b0, s, 0, 16'h0, 8'h00);
        run_op(5, 1'b0, 0, 0, 16'h0, 8'h3C);   // R1 stack pointer starts at 0xFFFF

        // Mode sweep over X, Y, Z and corner pointer values
        for (int s = 0; s < 3; s++)
            for (int v = 0; v < 4; v++)
                for (int m = 0; m < 5; m++)
                    for (int w = 0; w < 2; w++) begin
                        run_op(7, 1'b0, s, 0, vals[v], 8'h00);
                        run_op(m, w[0], s, (v * 17 + m) % 64, vals[v] ^ 16'h5A5A,
                               8'(v * 16 + m));
                        run_op(0, 1'b0, s, 0, 16'h0, 8'h00);
                    end

        // R6: full displacement sweep with carry wrap
        for (int s = 1; s < 3; s++) begin
            run_op(7, 1'b0, s, 0, 16'hFFF0, 8'h00);
            for (int d = 0; d < 64; d++) run_op(3, d[0], s, d, 16'h0, 8'(d));
            run_op(0, 1'b0, s, 0, 16'h0, 8'h00);
        end

        // R12: refused requests leave every pointer alone
        run_op(7, 1'b0, 0, 0, 16'h4444, 8'h00);
        run_op(3, 1'b0, 0, 5, 16'h0, 8'h00);
        run_op(3, 1'b1, 3, 5, 16'h0, 8'h00);
        for (int m = 0; m < 3; m++) run_op(m, 1'b0, 3, 0, 16'h0, 8'h00);
        run_op(0, 1'b0, 0, 0, 16'h0, 8'h00);
        run_op(6, 1'b0, 0, 0, 16'h0, 8'h00);

        // R8 R9: stack across address zero
        run_op(7, 1'b0, 3, 0, 16'h0001, 8'h00);
        for (int i = 0; i < 3; i++) run_op(5, 1'b0, i, 0, 16'h0, 8'(8'h70 + i));
        for (int i = 0; i < 3; i++) run_op(6, 1'b1, i, 0, 16'h0, 8'h00);
        run_op(5, 1'b0, 1, 0, 16'h0, 8'h11);

        // R11: request presented during preparation is ignored
        run_op(7, 1'b0, 0, 0, 16'h0100, 8'h00);
        req_valid = 1'b1; req_mode = 3'd2; req_write = 1'b0; req_sel = 2'd0;
        @(negedge clk);
        req_mode = 3'd7; req_addr = 16'hAAAA; req_sel = 2'd0;
        chk("R11", "busy ready", {31'd0, req_ready}, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "busy done", {31'd0, done}, 1);
        chk("R11", "busy addr", {16'd0, mem_addr}, 32'h00FF);
        mp[0] = 16'h00FF;
        run_op(0, 1'b0, 0, 0, 16'h0, 8'h00);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule